// File: doc/BRIEF.md
# Packed RGB555 SWAR Colour Averager

This unit blends pairs of 15-bit colours (three 5-bit channels each) held in 16-bit lanes. Two lanes share a 32-bit word, so each operation blends two independent colour pairs. The channels are never split apart. The datapath uses only bitwise XOR and AND, channel-boundary masks, shifts and one wide add per lane. Masks clear the low bits of every channel before each right shift, so no bit crosses into the channel below. The lanes are aligned so that no carry ever leaves a channel.

Two blends are available. The half blend gives the floor mean of the two operands. The three-quarter blend weights operand `a` three times as heavily as `b`. It is built from three shifted partial terms, and each of those terms truncates on its own, so this blend can land one step below the exact floor of (3a+b)/4.

The unit is a two-stage pipeline. It accepts one operation in every cycle that `valid_i` is high, and the result appears with `valid_o` two cycles later. It is meant as a drop-in blend engine for a scaler or compositor datapath.

Top module: `swar_avg_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `result_o` is 0.
- R2: `valid_o` equals `valid_i` from two clock edges earlier. An operation can be accepted on every cycle.
- R3: With `mode_i` = 0, each channel of the result is floor((ca+cb)/2). Channels sit at bits [4:0], [9:5] and [14:10] of each lane.
- R4: With `mode_i` = 1, each channel is floor((ca^cb)/4) + floor((ca&~cb)/2) + (ca&cb), computed on the 5-bit channel values.
- R5: With `mode_i` = 1, each channel is at most floor((3ca+cb)/4) and at least one less than that.
- R6: Lane 0 occupies bits [15:0] and lane 1 occupies bits [31:16]. The contents of one lane never affect the result of the other.
- R7: Bit 15 of each lane (bits 15 and 31) is ignored on input and is always 0 on `result_o`.
- R8: `result_o` changes only when `valid_o` is high. Otherwise it holds the last result.
- R9: Each operation uses its own `mode_i`, even when the mode alternates on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present on this cycle |
| mode_i | input | 1 | 0: half blend, 1: three-quarter blend (a weighted) |
| a_i | input | 32 | Two packed RGB555 operands a |
| b_i | input | 32 | Two packed RGB555 operands b |
| valid_o | output | 1 | Result present |
| result_o | output | 32 | Two packed blended colours |

## Verification
The bench sweeps every pair of 5-bit values through one channel in both modes and compares each result with a per-channel integer model. This sweep exposes a mask that lets a shifted bit fall into the next channel, which would show up as corrupted low bits in green or red. Extreme patterns check the edges of the format. All-ones against zero shows where the three-quarter blend truncates, and set pad bits show whether bit 15 leaks into the sum or the output. A design that shared a mask or carry across the lane boundary would disturb the other lane in these tests.

Streams of random operands alternate the mode every cycle and include bubbles. They catch a mode that is not carried along the pipeline with its data, a result register that changes on an idle cycle, and a valid pipeline of the wrong depth. A reset applied in the middle of traffic must clear both outputs.

// File: rtl/swar_avg_pkg.sv
package swar_avg_pkg;
  localparam int unsigned CH_W   = 5;
  localparam int unsigned CH_N   = 3;
  localparam int unsigned LANE_W = CH_W * CH_N + 1;

  typedef enum logic {
    MODE_HALF   = 1'b0,
    MODE_THREEQ = 1'b1
  } blend_mode_e;

  // Set the lowest nbits of every channel in a lane
  function automatic logic [LANE_W-1:0] chan_low_mask(int unsigned nbits);
    logic [LANE_W-1:0] m;
    m = '0;
    for (int unsigned c = 0; c < CH_N; c++)
      for (int unsigned k = 0; k < nbits; k++)
        m[c*CH_W+k] = 1'b1;
    return m;
  endfunction

  // Bits belonging to channels (pad bit cleared)
  function automatic logic [LANE_W-1:0] chan_payload_mask();
    logic [LANE_W-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < CH_W * CH_N; k++) m[k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/swar_avg_terms.sv
module swar_avg_terms
  import swar_avg_pkg::*;
(
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  blend_mode_e       mode_i,
  output logic [LANE_W-1:0] t_diff_o,
  output logic [LANE_W-1:0] t_amb_o,
  output logic [LANE_W-1:0] t_both_o
);
  localparam logic [LANE_W-1:0] PAY   = chan_payload_mask();
  localparam logic [LANE_W-1:0] LOW1  = chan_low_mask(1);
  localparam logic [LANE_W-1:0] LOW2  = chan_low_mask(2);

  logic [LANE_W-1:0] a_c, b_c, x_ab;

  assign a_c  = a_i & PAY;
  assign b_c  = b_i & PAY;
  assign x_ab = a_c ^ b_c;

  always_comb begin
    t_both_o = a_c & b_c;
    if (mode_i == MODE_HALF) begin
      t_diff_o = (x_ab & ~LOW1) >> 1;
      t_amb_o  = '0;
    end else begin
      t_diff_o = (x_ab & ~LOW2) >> 2;
      t_amb_o  = ((a_c & ~b_c) & ~LOW1) >> 1;
    end
  end
endmodule

// File: rtl/swar_avg_lane.sv
module swar_avg_lane
  import swar_avg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_terms_i,
  input  logic              ld_sum_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  blend_mode_e       mode_i,
  output logic [LANE_W-1:0] res_o
);
  localparam logic [LANE_W-1:0] PAY = chan_payload_mask();

  logic [LANE_W-1:0] diff_d, amb_d, both_d;
  logic [LANE_W-1:0] diff_q, amb_q, both_q;
  logic [LANE_W-1:0] sum_d;

  swar_avg_terms u_terms (
    .a_i      (a_i),
    .b_i      (b_i),
    .mode_i   (mode_i),
    .t_diff_o (diff_d),
    .t_amb_o  (amb_d),
    .t_both_o (both_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diff_q <= '0;
      amb_q  <= '0;
      both_q <= '0;
    end else if (ld_terms_i) begin
      diff_q <= diff_d;
      amb_q  <= amb_d;
      both_q <= both_d;
    end
  end

  // Each channel sum stays <= 31, so no carry crosses a channel
  assign sum_d = (diff_q + amb_q + both_q) & PAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       res_o <= '0;
    else if (ld_sum_i) res_o <= sum_d;
  end
endmodule

// File: rtl/swar_avg_unit.sv
module swar_avg_unit
  import swar_avg_pkg::*;
#(
  parameter int unsigned LANES = 2,
  localparam int unsigned W    = LANES * LANE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         mode_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] result_o
);
  logic        vld_s1;
  blend_mode_e mode_sel;

  assign mode_sel = blend_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_s1  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      vld_s1  <= valid_i;
      valid_o <= vld_s1;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    swar_avg_lane u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ld_terms_i (valid_i),
      .ld_sum_i   (vld_s1),
      .a_i        (a_i[l*LANE_W +: LANE_W]),
      .b_i        (b_i[l*LANE_W +: LANE_W]),
      .mode_i     (mode_sel),
      .res_o      (result_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/swar_avg_chk.sv
module swar_avg_chk
  import swar_avg_pkg::*;
#(
  parameter int unsigned LANES = 2,
  localparam int unsigned W    = LANES * LANE_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         mode_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         valid_o,
  input logic [W-1:0] result_o
);
  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  function automatic logic pads_clear(logic [W-1:0] r);
    logic ok;
    ok = 1'b1;
    for (int unsigned l = 0; l < LANES; l++)
      if (r[l*LANE_W + LANE_W - 1]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic chans_between(logic [W-1:0] r, logic [W-1:0] a, logic [W-1:0] b);
    logic ok;
    logic [CH_W-1:0] cr, ca, cb;
    ok = 1'b1;
    for (int unsigned l = 0; l < LANES; l++)
      for (int unsigned c = 0; c < CH_N; c++) begin
        cr = r[l*LANE_W + c*CH_W +: CH_W];
        ca = a[l*LANE_W + c*CH_W +: CH_W];
        cb = b[l*LANE_W + c*CH_W +: CH_W];
        if (ca <= cb) begin
          if (cr < ca || cr > cb) ok = 1'b0;
        end else begin
          if (cr < cb || cr > ca) ok = 1'b0;
        end
      end
    return ok;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_IDLE: assert (!valid_o && result_o == '0); // R1
  end

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2) |-> (valid_o == $past(valid_i, 2))); // R2

  AST_HALF_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2 && valid_o && !$past(mode_i, 2))
      |-> chans_between(result_o, $past(a_i, 2), $past(b_i, 2))); // R3

  AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pads_clear(result_o)); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age != 2'd0 && !valid_o) |-> $stable(result_o)); // R8
endmodule

bind swar_avg_unit swar_avg_chk #(.LANES(LANES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .mode_i   (mode_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/swar_avg_unit_test.sv
module swar_avg_unit_test;
  localparam int NV = 8;
  localparam logic [31:0] TV_A[NV] = '{32'h0000_0000, 32'h7FFF_7FFF, 32'h0000_0000, 32'hFFFF_FFFF,
                                      32'hFFFF_FFFF, 32'h0001_0003, 32'h0000_0003, 32'h8000_8000};
  localparam logic [31:0] TV_B[NV] = '{32'h7FFF_7FFF, 32'h0000_0000, 32'h7FFF_7FFF, 32'hFFFF_FFFF,
                                      32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 32'h8000_8000};
  localparam logic        TV_M[NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] TV_E[NV] = '{32'h3DEF_3DEF, 32'h5AD6_5AD6, 32'h1CE7_1CE7, 32'h7FFF_7FFF,
                                      32'h7FFF_7FFF, 32'h0000_0002, 32'h0000_0001, 32'h0000_0000};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int checks = 0, failures = 0;
  logic        pv1 = 0, pv2 = 0, pm1 = 0, pm2 = 0;
  logic [31:0] pa1 = 0, pa2 = 0, pb1 = 0, pb2 = 0, pe1 = 0, pe2 = 0;
  string       pt1 = "", pt2 = "";
  logic [31:0] last_res = '0;

  always #2 clk_i = ~clk_i;

  swar_avg_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic m);
    logic [31:0] r;
    logic [4:0] ca, cb, cr;
    r = '0;
    for (int l = 0; l < 2; l++)
      for (int c = 0; c < 3; c++) begin
        ca = a[l*16 + c*5 +: 5];
        cb = b[l*16 + c*5 +: 5];
        if (!m) cr = 5'((6'(ca) + 6'(cb)) >> 1);
        else    cr = ((ca ^ cb) >> 2) + ((ca & ~cb) >> 1) + (ca & cb);
        r[l*16 + c*5 +: 5] = cr;
      end
    return r;
  endfunction

  function automatic logic weighted_near(logic [31:0] r, logic [31:0] a, logic [31:0] b);
    int ca, cb, cr, t;
    for (int l = 0; l < 2; l++)
      for (int c = 0; c < 3; c++) begin
        ca = int'(a[l*16 + c*5 +: 5]);
        cb = int'(b[l*16 + c*5 +: 5]);
        cr = int'(r[l*16 + c*5 +: 5]);
        t  = (3*ca + cb) / 4;
        if (cr > t || cr + 1 < t) return 1'b0;
      end
    return 1'b1;
  endfunction

  task automatic chk(logic ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out();
    chk(valid_o == pv2, "R2 valid_o", 32'(valid_o), 32'(pv2));
    if (pv2) begin
      chk(result_o == pe2, pt2, result_o, pe2);
      if (pm2) chk(weighted_near(result_o, pa2, pb2), "R5 weighted bound", result_o, pe2);
      chk(result_o[15] == 1'b0 && result_o[31] == 1'b0, "R7 pad", result_o, result_o & 32'h7FFF_7FFF);
    end else begin
      chk(result_o == last_res, "R8 hold", result_o, last_res);
    end
    last_res = result_o;
  endtask

  task automatic step(logic v, logic [31:0] a, logic [31:0] b, logic m, logic [31:0] e, string tag);
    @(negedge clk_i);
    check_out();
    valid_i = v; a_i = a; b_i = b; mode_i = m;
    pv2 = pv1; pa2 = pa1; pb2 = pb1; pm2 = pm1; pe2 = pe1; pt2 = pt1;
    pv1 = v;   pa1 = a;   pb1 = b;   pm1 = m;   pe1 = e;   pt1 = tag;
  endtask

  task automatic op(logic [31:0] a, logic [31:0] b, logic m, string tag);
    step(1'b1, a, b, m, model(a, b, m), tag);
  endtask

  task automatic idle();
    step(1'b0, '0, '0, 1'b0, '0, "");
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!valid_o && result_o == '0, "R1 reset", result_o, '0);
    rst_ni = 1'b1;

    // Table of hand-computed vectors (R3/R4/R6/R7)
    for (int i = 0; i < NV; i++) step(1'b1, TV_A[i], TV_B[i], TV_M[i], TV_E[i], "R3/R4 table");
    idle(); idle();

    // R6: one lane saturated, other lane zero, in both directions
    op(32'h7FFF_0000, 32'h0000_0000, 1'b1, "R6 lane1 only");
    op(32'h0000_7FFF, 32'h0000_0000, 1'b1, "R6 lane0 only");
    op(32'h0000_7FFF, 32'h7FFF_0000, 1'b0, "R6 crossed");
    // R7: pad bits set must not leak
    op(32'h8000_8001, 32'h8000_8001, 1'b0, "R7 pad ignored");
    op(32'hFFFF_8000, 32'h8000_FFFF, 1'b1, "R7 pad ignored");
    idle(); idle();

    // Exhaustive channel sweep: lo red, hi green
    for (int ia = 0; ia < 32; ia++)
      for (int ib = 0; ib < 32; ib++)
        for (int m = 0; m < 2; m++)
          op({11'd0, 5'(ia), 5'd0, 11'd0, 5'(ib)} | {6'd0, 5'(ib), 21'd0},
             {6'd0, 5'(ia), 21'd0} | {27'd0, 5'(ia)},
             1'(m), m[0] ? "R4 sweep" : "R3 sweep");

    // Random stream, mode alternating every op, with bubbles (R9, R8)
    for (int k = 0; k < 3000; k++) begin
      if (k % 7 == 3) idle();
      else op($urandom, $urandom, 1'(k & 1), (k & 1) ? "R9 R4 stream" : "R9 R3 stream");
    end
    idle(); idle(); idle();

    // R1: reset during traffic
    op(32'h1234_5678, 32'h7654_4321, 1'b0, "R3 pre-reset");
    op(32'h7FFF_7FFF, 32'h0000_0000, 1'b0, "R3 pre-reset");
    @(negedge clk_i);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    #1;
    chk(!valid_o && result_o == '0, "R1 mid reset", result_o, '0);
    pv1 = 0; pv2 = 0; last_res = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(); idle();
    op(32'h0000_0003, 32'h0000_0000, 1'b1, "R4 after reset");
    idle(); idle(); idle();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule